// File: doc/BRIEF.md
# Multi-Mode PWM Channel Bank

This block is a bank of pulse-width channels that all run from one shared timebase. A 16-bit fractional rate word is added to a 16-bit phase accumulator on every clock. Each carry out of that accumulator advances a common 12-bit duty counter, so the counter runs at clk × rate / 65536. Each channel picks its own period length of 9, 10, 11 or 12 counter bits. Each channel has a magnitude with a sign and drives two pins. What those pins carry depends on the channel's pin mode: pulse plus direction, the same two signals swapped, up/down steering by sign, or a density mode placeholder.

A host loads the block through a single-cycle write port. The port reaches four register kinds: a per-channel value, a per-channel mode, the shared rate word and the shared enable mask. Each channel can double-buffer its value, so a new duty takes effect only at the start of that channel's next period. Each channel also has an active-low enable output for downstream drive stages.

Top module: `pwm_bank`

## Requirements
- R1: After a synchronous reset, all registers are cleared, every pin_a and pin_b output is 0, and every en_n output is 1.
- R2: The duty counter advances by one on each carry out of the 16-bit accumulator, which adds the rate word every clock. With rate 0x8000 it advances every 2 clocks, with 0x4000 every 4 clocks, and with rate 0 it holds.
- R3: Mode bits [1:0] select the period width: 0 selects 9 bits, 1 selects 10, 2 selects 11 and 3 selects 12. One period lasts 2^width counter steps and holds exactly one high pulse when the magnitude is nonzero and not full scale.
- R4: The pulse is high while the low width bits of the counter are below the magnitude. The magnitude is taken from value bits [27:16] and only its low width bits are used. A magnitude of 0 is always low, and 2^width − 1 is high for all but one step per period.
- R5: Pin mode 0 (mode bits [4:3] = 0) puts the pulse on pin_a and the sign (value bit 31) on pin_b.
- R6: Pin mode 1 puts the sign on pin_a and the pulse on pin_b.
- R7: Pin mode 2 puts the pulse on pin_a (up) when the sign is 0 and on pin_b (down) when the sign is 1. The other pin is held low, so both pins are never high at once.
- R8: Pin mode 3 holds pin_a low and puts the sign on pin_b.
- R9: When mode bit 5 is set, a written value is not used until the counter enters the first step of the channel's period. When bit 5 is clear, the written value is used at once.
- R10: Bit i of the enable mask enables channel i. A disabled channel drives both pins low, and en_n[i] is the inverse of the enable bit.
- R11: A write with wr_en high stores wr_data in the register chosen by wr_kind: 0 is the value of channel wr_chan, 1 is the mode of channel wr_chan, 2 is the rate word (bits [15:0]) and 3 is the enable mask (bits [NCH-1:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 value, 1 mode, 2 rate, 3 enable |
| wr_chan | input | CH_W | Channel index for value and mode writes |
| wr_data | input | 32 | Write data |
| pin_a | output | NCH | First output pin of each channel |
| pin_b | output | NCH | Second output pin of each channel |
| en_n | output | NCH | Active-low enable of each channel |

## Verification
The properties assume that writes come only through the port and that no channel changes its pin mode inside the one-cycle window between the mode register and the pin flops. The bench meets this by letting the outputs settle for several clocks after every write before it samples. The hold checks assume that a zero rate word keeps the accumulator from ever carrying. The bench therefore freezes the counter with rate 0 for every static pin-mode and double-buffer check. It measures duty only with rate words that divide 65536 exactly, so that a window of one period contains a whole number of pulses.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  typedef enum logic [1:0] {
    PIN_PWM_DIR = 2'd0,
    PIN_DIR_PWM = 2'd1,
    PIN_UP_DOWN = 2'd2,
    PIN_DENSITY = 2'd3
  } pin_mode_e;

  typedef enum logic [1:0] {
    WK_VALUE  = 2'd0,
    WK_MODE   = 2'd1,
    WK_RATE   = 2'd2,
    WK_ENABLE = 2'd3
  } wr_kind_e;

  localparam int MODE_W    = 6;
  localparam int DBUF_BIT  = 5;
  localparam int PMODE_LSB = 3;
  localparam int SIGN_BIT  = 31;
  localparam int MAG_LSB   = 16;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int RATE_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  output logic              tick,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_nxt
);
  logic [RATE_W-1:0] acc_q;
  logic [RATE_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, rate};
  assign tick    = sum[RATE_W];
  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= sum[RATE_W-1:0];
      if (tick) cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int MAXW   = 12,
  parameter int RATE_W = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_kind,
  input  logic [CH_W-1:0]              wr_chan,
  input  logic [31:0]                  wr_data,
  output logic [NCH-1:0][MAXW-1:0]     mag_q,
  output logic [NCH-1:0]               sign_q,
  output logic [NCH-1:0][MODE_W-1:0]   mode_q,
  output logic [RATE_W-1:0]            rate_q,
  output logic [NCH-1:0]               en_q
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q  <= '0;
      sign_q <= '0;
      mode_q <= '0;
      rate_q <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      unique case (wr_kind_e'(wr_kind))
        WK_VALUE: begin
          for (int i = 0; i < NCH; i++) begin
            if (wr_chan == CH_W'(i)) begin
              mag_q[i]  <= wr_data[MAG_LSB +: MAXW];
              sign_q[i] <= wr_data[SIGN_BIT];
            end
          end
        end
        WK_MODE: begin
          for (int i = 0; i < NCH; i++) begin
            if (wr_chan == CH_W'(i)) mode_q[i] <= wr_data[MODE_W-1:0];
          end
        end
        WK_RATE:   rate_q <= wr_data[RATE_W-1:0];
        WK_ENABLE: en_q   <= wr_data[NCH-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int MAXW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [MAXW-1:0]   cnt_q,
  input  logic [MAXW-1:0]   cnt_nxt,
  input  logic [MAXW-1:0]   mag,
  input  logic              sign,
  input  logic [MODE_W-1:0] mode,
  input  logic              en,
  output logic [MAXW-1:0]   act_mag,
  output logic              pin_a,
  output logic              pin_b,
  output logic              en_n
);
  localparam int MINW = MAXW - 3;

  logic [MAXW-1:0] mask;
  logic            period_start;
  logic            act_sign;
  logic            pwm_on;
  logic            a_nxt, b_nxt;
  pin_mode_e       pmode;

  assign mask         = ~({MAXW{1'b1}} << (MINW + int'(mode[1:0])));
  assign period_start = tick && ((cnt_nxt & mask) == '0);
  assign pwm_on       = (cnt_q & mask) < (act_mag & mask);
  assign pmode        = pin_mode_e'(mode[PMODE_LSB +: 2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mag  <= '0;
      act_sign <= 1'b0;
    end else if (!mode[DBUF_BIT] || period_start) begin
      act_mag  <= mag;
      act_sign <= sign;
    end
  end

  always_comb begin
    unique case (pmode)
      PIN_PWM_DIR: begin a_nxt = pwm_on;             b_nxt = act_sign;          end
      PIN_DIR_PWM: begin a_nxt = act_sign;           b_nxt = pwm_on;            end
      PIN_UP_DOWN: begin a_nxt = pwm_on & ~act_sign; b_nxt = pwm_on & act_sign; end
      default:     begin a_nxt = 1'b0;               b_nxt = act_sign;          end
    endcase
    if (!en) begin
      a_nxt = 1'b0;
      b_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_a <= 1'b0;
      pin_b <= 1'b0;
      en_n  <= 1'b1;
    end else begin
      pin_a <= a_nxt;
      pin_b <= b_nxt;
      en_n  <= ~en;
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int MAXW   = 12,
  parameter int RATE_W = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_kind,
  input  logic [CH_W-1:0] wr_chan,
  input  logic [31:0]     wr_data,
  output logic [NCH-1:0]  pin_a,
  output logic [NCH-1:0]  pin_b,
  output logic [NCH-1:0]  en_n
);
  logic [NCH-1:0][MAXW-1:0]   mag_q;
  logic [NCH-1:0]             sign_q;
  logic [NCH-1:0][MODE_W-1:0] mode_q;
  logic [RATE_W-1:0]          rate_q;
  logic [NCH-1:0]             en_q;
  logic [NCH-1:0][MAXW-1:0]   act_mag;
  logic                       tick;
  logic [MAXW-1:0]            cnt_q;
  logic [MAXW-1:0]            cnt_nxt;

  pwm_regs #(.NCH(NCH), .MAXW(MAXW), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_chan(wr_chan),
    .wr_data(wr_data), .mag_q(mag_q), .sign_q(sign_q), .mode_q(mode_q),
    .rate_q(rate_q), .en_q(en_q)
  );

  pwm_tick_gen #(.RATE_W(RATE_W), .CNT_W(MAXW)) u_tick (
    .clk(clk), .rst(rst), .rate(rate_q), .tick(tick), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_chan #(.MAXW(MAXW)) u_chan (
      .clk(clk), .rst(rst), .tick(tick), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
      .mag(mag_q[g]), .sign(sign_q[g]), .mode(mode_q[g]), .en(en_q[g]),
      .act_mag(act_mag[g]), .pin_a(pin_a[g]), .pin_b(pin_b[g]), .en_n(en_n[g])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int MAXW   = 12,
  parameter int RATE_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic [RATE_W-1:0]          rate_q,
  input logic [MAXW-1:0]            cnt_q,
  input logic [NCH-1:0]             en_q,
  input logic [NCH-1:0][MODE_W-1:0] mode_q,
  input logic [NCH-1:0][MAXW-1:0]   act_mag,
  input logic [NCH-1:0]             pin_a,
  input logic [NCH-1:0]             pin_b,
  input logic [NCH-1:0]             en_n
);
  p_frozen_count_r2: assert property (@(posedge clk) disable iff (rst)
    (rate_q == '0) |=> $stable(cnt_q));

  for (genvar i = 0; i < NCH; i++) begin : g_prop
    p_updown_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
      (mode_q[i][PMODE_LSB +: 2] == 2'd2) |=> !(pin_a[i] && pin_b[i]));

    p_dbuf_hold_r9: assert property (@(posedge clk) disable iff (rst)
      ((rate_q == '0) && mode_q[i][DBUF_BIT]) |=> $stable(act_mag[i]));

    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      en_n[i] |-> (!pin_a[i] && !pin_b[i]));

    p_enable_out_r10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (en_n[i] == !$past(en_q[i])));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .MAXW(MAXW), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .rate_q(rate_q), .cnt_q(cnt_q), .en_q(en_q),
  .mode_q(mode_q), .act_mag(act_mag), .pin_a(pin_a), .pin_b(pin_b), .en_n(en_n)
);

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [1:0]  wr_chan = '0;
  logic [31:0] wr_data = '0;
  logic [NCH-1:0] pin_a, pin_b, en_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pwm_bank #(.NCH(NCH), .MAXW(12), .RATE_W(16)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_chan(wr_chan),
    .wr_data(wr_data), .pin_a(pin_a), .pin_b(pin_b), .en_n(en_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int ch, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind[1:0]; wr_chan = ch[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] val(input int mag, input bit neg);
    return {neg, 15'd0, 16'd0} | (32'(mag) << 16);
  endfunction

  task automatic measure(input int ch, input int n, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0; prev = pin_a[ch];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pin_a[ch]) hi++;
      if (pin_a[ch] && !prev) rises++;
      prev = pin_a[ch];
    end
  endtask

  task automatic t_reset;
    chk("R1 pin_a", int'(pin_a), 0);
    chk("R1 pin_b", int'(pin_b), 0);
    chk("R1 en_n", int'(en_n), 15);
  endtask

  task automatic t_enable;
    wr(3, 0, 32'h5);
    settle(3);
    chk("R10 R11 en_n mask", int'(en_n), 4'b1010);
    wr(3, 0, 32'hF);
    settle(3);
    chk("R10 en_n all on", int'(en_n), 0);
  endtask

  task automatic t_pin_modes;
    wr(0, 0, val(5, 1'b0)); wr(1, 0, 32'h00); settle(4);
    chk("R5 mode0 sign0 a", int'(pin_a[0]), 1);
    chk("R5 mode0 sign0 b", int'(pin_b[0]), 0);
    wr(0, 0, val(5, 1'b1)); settle(4);
    chk("R5 mode0 sign1 b", int'(pin_b[0]), 1);
    wr(0, 0, val(5, 1'b0)); wr(1, 0, 32'h08); settle(4);
    chk("R6 swapped a", int'(pin_a[0]), 0);
    chk("R6 swapped b", int'(pin_b[0]), 1);
    wr(1, 0, 32'h10); settle(4);
    chk("R7 up a", int'(pin_a[0]), 1);
    chk("R7 up b", int'(pin_b[0]), 0);
    wr(0, 0, val(5, 1'b1)); settle(4);
    chk("R7 down a", int'(pin_a[0]), 0);
    chk("R7 down b", int'(pin_b[0]), 1);
    wr(1, 0, 32'h18); settle(4);
    chk("R8 density a", int'(pin_a[0]), 0);
    chk("R8 density b", int'(pin_b[0]), 1);
    wr(0, 2, val(0, 1'b0)); settle(4);
    chk("R4 zero mag low", int'(pin_a[2]), 0);
  endtask

  task automatic t_disable;
    wr(0, 3, val(7, 1'b1)); settle(4);
    chk("R10 enabled a", int'(pin_a[3]), 1);
    wr(3, 0, 32'h7); settle(4);
    chk("R10 disabled a", int'(pin_a[3]), 0);
    chk("R10 disabled b", int'(pin_b[3]), 0);
    chk("R10 disabled en_n", int'(en_n[3]), 1);
    wr(3, 0, 32'hF); settle(3);
  endtask

  task automatic t_dbuf;
    int hi, rises;
    wr(1, 1, 32'h00); wr(0, 1, val(5, 1'b0)); settle(4);
    chk("R9 immediate load", int'(pin_a[1]), 1);
    wr(1, 1, 32'h20); wr(0, 1, val(0, 1'b0)); settle(20);
    chk("R9 held until period", int'(pin_a[1]), 1);
    wr(2, 0, 32'h8000); settle(1100);
    measure(1, 1024, hi, rises);
    chk("R9 loaded at period", hi, 0);
  endtask

  task automatic t_duty;
    int hi, rises;
    wr(1, 0, 32'h00); wr(0, 0, val(100, 1'b0)); settle(1100);
    measure(0, 2048, hi, rises);
    chk("R3 R4 w9 duty", hi, 400);
    chk("R3 w9 pulses", rises, 2);
    wr(1, 0, 32'h03); wr(0, 0, val(3000, 1'b0)); settle(8300);
    measure(0, 8192, hi, rises);
    chk("R3 R4 w12 duty", hi, 6000);
    wr(1, 0, 32'h02); wr(0, 0, val(2047, 1'b0)); settle(4200);
    measure(0, 4096, hi, rises);
    chk("R4 w11 full scale", hi, 4094);
    wr(1, 0, 32'h00); wr(0, 0, val(12'h3FF, 1'b0)); settle(1100);
    measure(0, 1024, hi, rises);
    chk("R4 upper bits ignored", hi, 1022);
  endtask

  task automatic t_rate;
    int hi, rises;
    wr(2, 0, 32'h4000); wr(0, 0, val(256, 1'b0)); settle(2100);
    measure(0, 2048, hi, rises);
    chk("R2 rate 0x4000 duty", hi, 1024);
    chk("R2 rate 0x4000 pulses", rises, 1);
    wr(2, 0, 32'h0); settle(4);
    measure(0, 300, hi, rises);
    chk("R2 frozen no edges", rises, 0);
  endtask

  initial begin
    settle(4);
    rst = 1'b0;
    settle(2);
    t_reset;
    t_enable;
    t_pin_modes;
    t_disable;
    t_dbuf;
    t_duty;
    t_rate;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule